// File: doc/BRIEF.md
# Seven-Slot Multi-Lane Deserializer

This block turns a set of serial data lanes back into one wide parallel word. Every lane carries seven bit slots per frame, and a forwarded clock lane carries a fixed seven-slot pattern. The block runs on a sample clock at seven times the frame rate, so it takes in one bit per lane on every sample edge. The clock-lane pattern 1100011 marks where each frame starts. Once the pattern has repeated at the right spacing for enough frames, the block declares lock. After that it writes one parallel word per frame and produces a parallel output clock at the frame rate. That clock is placed so that the word is stable on both sides of its rising edge.

With four lanes the word is 28 bits wide. A narrow mode drops the top lane, which leaves 21 live bits. An active-low power-down forces every output to a defined low state. When power returns, a settle interval must pass before the block looks for frames again. If the clock lane stops toggling, the block drops into a fail-safe state: the output clock stays low and lock is cleared. The block starts hunting again on the first transition it sees.

The control is a six-state machine. OFF covers power-down and reset. SETTLE counts out the settle interval. HUNT looks for the pattern at any position. VERIFY counts consecutive frames that match at the expected spacing. LOCK delivers words. FSAFE holds the clock lane's idle condition. The transitions are:
- power-down goes to OFF from any state.
- OFF goes to SETTLE once power is on.
- SETTLE goes to HUNT when the settle count ends.
- HUNT goes to VERIFY when the pattern is found.
- VERIFY goes to LOCK when enough frames have matched, or back to HUNT on a miss.
- LOCK goes to HUNT on a miss.
- HUNT, VERIFY or LOCK go to FSAFE when the idle limit is reached.
- FSAFE goes to HUNT on a clock-lane transition.

Top module: `deser7_rx`

## Requirements
- R1: In wide mode, slot k of lane n (slot 0 being the first bit of a frame, the clock lane reading 1,1,0,0,0,1,1 over slots 0 to 6) appears on output bit 7·n+k of the word.
- R2: In narrow mode, output bits 21 to 27 are 0 whatever the top lane carries, and lanes 0 to 2 map as in R1.
- R3: After the settle interval, locked rises on the edge that delivers the LOCK_FRAMES-th consecutive correctly spaced clock-lane frame, and not earlier.
- R4: The word changes only on the sample edge that follows the last slot of a matched frame, and holds for the rest of the frame.
- R5: The output clock is high in frame phases 3, 4 and 5 while locked (phase 0 is the cycle after a word update) and low in all other cases.
- R6: A clock-lane mismatch at an expected frame boundary clears locked on the next edge, and the previous word is held.
- R7: When the clock lane shows no transition for IDLE_LIM sample clocks, failsafe goes to 1 and locked and the output clock go low. The first transition afterwards returns the block to hunting and clears failsafe.
- R8: While power-down is asserted, the word, the output clock, locked and failsafe are 0 from the next edge on. After release the block waits SETTLE_CYC sample clocks before hunting.
- R9: Reset leaves the word, the output clock, locked and failsafe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| narrow | input | 1 | 1 selects the reduced mode that drops the top lane |
| lane_in | input | LANES | One serial bit per data lane per sample clock |
| clk_lane | input | 1 | Forwarded clock-lane bit per sample clock |
| par_data | output | 7·LANES | Rebuilt parallel word |
| par_clk | output | 1 | Parallel output clock at frame rate |
| locked | output | 1 | Frame alignment achieved |
| failsafe | output | 1 | Clock lane idle too long |

## Verification
The hardest cases to reach from the ports are the exact frame in which lock is gained and the exact frame in which it is regained. Lock timing depends on how the settle window lines up with the frame grid, and the bench derives that frame number from SETTLE_CYC and LOCK_FRAMES. The stimulus restarts the frame stream at a known sample edge after reset, after power-down release and after a forced idle stretch. It also places a single corrupted clock-lane slot inside an otherwise clean locked stream. Random words are mixed with walking and alternating patterns so that every lane-to-bit mapping is seen.

// File: rtl/deser7_pkg.sv
package deser7_pkg;
    localparam int SLOTS = 7;
    // clock-lane slots 0..6 read 1,1,0,0,0,1,1; oldest bit sits in the MSB of a window
    localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

    typedef enum logic [2:0] {
        S_OFF,
        S_SETTLE,
        S_HUNT,
        S_VERIFY,
        S_LOCK,
        S_FSAFE
    } rx_state_t;
endpackage

// File: rtl/deser7_lane_shift.sv
module deser7_lane_shift
    import deser7_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [SLOTS-1:0] win
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win <= '0;
        else        win <= {win[SLOTS-2:0], din};
    end
endmodule

// File: rtl/deser7_align_fsm.sv
module deser7_align_fsm
    import deser7_pkg::*;
#(
    parameter int LOCK_FRAMES = 3,
    parameter int SETTLE_CYC  = 14,
    parameter int IDLE_LIM    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic [SLOTS-1:0] clk_win,
    output logic             capture,
    output logic             locked,
    output logic             par_clk,
    output logic             failsafe
);
    localparam int GW = $clog2(LOCK_FRAMES + 1);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int IW = $clog2(IDLE_LIM + 1);
    localparam logic [2:0] PH_LAST = 3'(SLOTS - 1);

    rx_state_t       st, nxt;
    logic [2:0]      phase;
    logic [GW-1:0]   good;
    logic [SW-1:0]   settle_cnt;
    logic [IW-1:0]   idle_cnt;
    logic            match, toggle, idle_hit, frame_end, tracking;

    assign match     = (clk_win == CLK_PAT);
    assign toggle    = clk_win[0] ^ clk_win[1];
    assign idle_hit  = (idle_cnt == IW'(IDLE_LIM));
    assign frame_end = (phase == PH_LAST);
    assign tracking  = (st == S_HUNT) || (st == S_VERIFY) || (st == S_LOCK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_OFF;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        if (!pwr_n) begin
            nxt = S_OFF;
        end else if (tracking && idle_hit) begin
            nxt = S_FSAFE;
        end else begin
            unique case (st)
                S_OFF:    nxt = S_SETTLE;
                S_SETTLE: if (settle_cnt == SW'(SETTLE_CYC - 1)) nxt = S_HUNT;
                S_HUNT:   if (match) nxt = S_VERIFY;
                S_VERIFY: if (frame_end) begin
                              if (!match)                          nxt = S_HUNT;
                              else if (good == GW'(LOCK_FRAMES - 1)) nxt = S_LOCK;
                          end
                S_LOCK:   if (frame_end && !match) nxt = S_HUNT;
                S_FSAFE:  if (toggle) nxt = S_HUNT;
                default:  nxt = S_OFF;
            endcase
        end
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase      <= '0;
            good       <= '0;
            settle_cnt <= '0;
            idle_cnt   <= '0;
        end else begin
            settle_cnt <= (st == S_SETTLE) ? settle_cnt + SW'(1) : '0;

            if (!pwr_n || toggle) idle_cnt <= '0;
            else if (!idle_hit)   idle_cnt <= idle_cnt + IW'(1);

            if (st == S_HUNT)
                phase <= '0;
            else if (st == S_VERIFY || st == S_LOCK)
                phase <= frame_end ? 3'd0 : phase + 3'd1;
            else
                phase <= '0;

            if (st == S_HUNT && nxt == S_VERIFY)
                good <= GW'(1);
            else if (st == S_VERIFY && frame_end && nxt == S_VERIFY)
                good <= good + GW'(1);
            else if (st != S_VERIFY)
                good <= '0;
        end
    end

    // outputs
    always_comb begin
        locked   = (st == S_LOCK);
        failsafe = (st == S_FSAFE);
        par_clk  = (st == S_LOCK) && (phase >= 3'd3) && (phase <= 3'd5);
        capture  = (nxt == S_LOCK) && frame_end;
    end

    assert_lock_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(good) == GW'(LOCK_FRAMES - 1)));

    assert_pclk_quiet_at_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !par_clk);

    assert_drop_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_n && st == S_LOCK && frame_end && !match && !idle_hit) |=> !locked);

    assert_idle_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_n && tracking && idle_hit) |=> (failsafe && !locked && !par_clk));

    assert_pdown_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> (!locked && !failsafe && !par_clk));
endmodule

// File: rtl/deser7_word_reg.sv
module deser7_word_reg
    import deser7_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_n,
    input  logic                   narrow,
    input  logic                   capture,
    input  logic [LANES*SLOTS-1:0] wins,
    output logic [LANES*SLOTS-1:0] data_q
);
    localparam int W = LANES * SLOTS;

    logic [W-1:0] mapped;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            if (n == LANES - 1) begin : g_top
                assign mapped[n*SLOTS+k] = narrow ? 1'b0 : wins[n*SLOTS+SLOTS-1-k];
            end else begin : g_low
                assign mapped[n*SLOTS+k] = wins[n*SLOTS+SLOTS-1-k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (!pwr_n)  data_q <= '0;
        else if (capture) data_q <= mapped;
    end

    assert_first_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_n && capture) |=> (data_q[0] == $past(wins[SLOTS-1])));

    assert_top_lane_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && narrow) |=> (data_q[W-1 -: SLOTS] == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_n && !capture) |=> $stable(data_q));

    assert_pdown_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> (data_q == '0));
endmodule

// File: rtl/deser7_rx.sv
module deser7_rx
    import deser7_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int LOCK_FRAMES = 3,
    parameter int SETTLE_CYC  = 14,
    parameter int IDLE_LIM    = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_n,
    input  logic                   narrow,
    input  logic [LANES-1:0]       lane_in,
    input  logic                   clk_lane,
    output logic [LANES*SLOTS-1:0] par_data,
    output logic                   par_clk,
    output logic                   locked,
    output logic                   failsafe
);
    localparam int W = LANES * SLOTS;

    logic [W-1:0]     wins;
    logic [SLOTS-1:0] clk_win;
    logic             capture;

    for (genvar n = 0; n < LANES; n++) begin : g_shift
        deser7_lane_shift i_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_in[n]),
            .win   (wins[n*SLOTS +: SLOTS])
        );
    end

    deser7_lane_shift i_clk_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (clk_lane),
        .win   (clk_win)
    );

    deser7_align_fsm #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .SETTLE_CYC  (SETTLE_CYC),
        .IDLE_LIM    (IDLE_LIM)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_n    (pwr_n),
        .clk_win  (clk_win),
        .capture  (capture),
        .locked   (locked),
        .par_clk  (par_clk),
        .failsafe (failsafe)
    );

    deser7_word_reg #(.LANES(LANES)) i_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_n   (pwr_n),
        .narrow  (narrow),
        .capture (capture),
        .wins    (wins),
        .data_q  (par_data)
    );
endmodule

// File: tb/test_deser7_rx.sv
module test_deser7_rx;
    localparam int LANES = 4;
    localparam int W     = LANES * 7;
    localparam int LOCKF = 3;
    localparam int SETTLE = 14;
    localparam int IDLE  = 20;
    localparam logic [6:0] SLOT_PAT = 7'b1100011; // slot k = SLOT_PAT[6-k]

    logic             clk = 1'b0;
    logic             rst_n, pwr_n, narrow, clk_lane;
    logic [LANES-1:0] lane_in;
    logic [W-1:0]     par_data;
    logic             par_clk, locked, failsafe;

    int n_chk = 0;
    int n_fail = 0;

    logic [W-1:0] prev_w;
    bit           prev_nar;
    bit           prev_ok;
    logic [W-1:0] k1_data;

    always #5 clk = ~clk;

    deser7_rx #(.LANES(LANES), .LOCK_FRAMES(LOCKF), .SETTLE_CYC(SETTLE), .IDLE_LIM(IDLE))
    i_deser7_rx (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .narrow(narrow),
        .lane_in(lane_in), .clk_lane(clk_lane),
        .par_data(par_data), .par_clk(par_clk), .locked(locked), .failsafe(failsafe)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] w, input bit nar);
        logic [W-1:0] r = w;
        if (nar) r[W-1 -: 7] = '0;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [W-1:0] rnd_word();
        return W'({$urandom, $urandom});
    endfunction

    task automatic run_frame(input logic [W-1:0] w, input bit corrupt, output bit lk);
        logic [W-1:0] held = '0;
        lk = 1'b0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (k == 1) begin
                lk = locked;
                held = par_data;
                k1_data = par_data;
                if (locked && prev_ok)
                    check(par_data == model(prev_w, prev_nar), prev_nar ? "R2 narrow word" : "R1 wide word",
                          par_data, model(prev_w, prev_nar));
            end
            if (k == 6) check(par_data == held, "R4 word held in frame", par_data, held);
            if (k == 2) check(par_clk == 1'b0, "R5 pclk low phase 1", par_clk, 0);
            if (k == 5) check(par_clk == lk, "R5 pclk high phase 4", par_clk, lk);
            for (int n = 0; n < LANES; n++) lane_in[n] = w[n*7+k];
            clk_lane = SLOT_PAT[6-k] ^ (corrupt && k == 3);
        end
        prev_w = w;
        prev_nar = narrow;
        prev_ok = !corrupt;
    endtask

    task automatic wait_lock(input int expect_idx, input string tag);
        int first = -1;
        bit lk;
        for (int i = 0; i <= expect_idx + 2; i++) begin
            run_frame(rnd_word(), 1'b0, lk);
            if (lk && first < 0) first = i;
            if (lk) break;
        end
        check(first == expect_idx, tag, first, expect_idx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        bit lk;
        logic [W-1:0] held_exp;
        int f_det;
        logic [W-1:0] dirs [4];
        void'($urandom(32'd2024));
        dirs[0] = 28'h0000001; dirs[1] = 28'h8000000;
        dirs[2] = 28'h5555555; dirs[3] = 28'hAAAAAAA;
        f_det = (SETTLE - 1) / 7;
        rst_n = 0; pwr_n = 1; narrow = 0; lane_in = '0; clk_lane = 0;
        prev_w = '0; prev_nar = 0; prev_ok = 0; k1_data = '0;
        repeat (4) @(negedge clk);
        check(par_data == '0 && !par_clk && !locked && !failsafe, "R9 reset state",
              {par_data, par_clk, locked, failsafe}, 0);
        rst_n = 1;

        // R3: lock frame after settle
        wait_lock(f_det + LOCKF, "R3 lock frame after reset");

        // R1: directed and random wide words
        for (int i = 0; i < 4; i++) run_frame(dirs[i], 1'b0, lk);
        for (int i = 0; i < 20; i++) run_frame(rnd_word(), 1'b0, lk);

        // R2: narrow mode
        narrow = 1; prev_ok = 0;
        for (int i = 0; i < 12; i++) run_frame(rnd_word(), 1'b0, lk);
        run_frame({W{1'b1}}, 1'b0, lk);
        run_frame(rnd_word(), 1'b0, lk);
        narrow = 0; prev_ok = 0;
        run_frame(rnd_word(), 1'b0, lk);
        run_frame(rnd_word(), 1'b0, lk);

        // R6: one corrupted clock-lane slot
        held_exp = model(prev_w, prev_nar);
        run_frame(rnd_word(), 1'b1, lk);
        run_frame(rnd_word(), 1'b0, lk);
        check(lk == 1'b0, "R6 lock cleared after miss", lk, 0);
        check(k1_data == held_exp, "R6 word held after miss", k1_data, held_exp);
        wait_lock(LOCKF - 1, "R6 relock after miss");
        for (int i = 0; i < 4; i++) run_frame(rnd_word(), 1'b0, lk);

        // R7: idle clock lane
        for (int c = 0; c < IDLE + 10; c++) begin
            @(negedge clk);
            clk_lane = 0;
            lane_in = LANES'($urandom);
        end
        @(negedge clk);
        check(failsafe == 1'b1, "R7 failsafe set", failsafe, 1);
        check(!locked && !par_clk, "R7 lock and pclk low", {locked, par_clk}, 0);
        prev_ok = 0;
        wait_lock(LOCKF, "R7 relock after idle");
        check(failsafe == 1'b0, "R7 failsafe cleared", failsafe, 0);
        for (int i = 0; i < 4; i++) run_frame(rnd_word(), 1'b0, lk);

        // R8: power-down
        @(negedge clk);
        pwr_n = 0;
        repeat (3) @(negedge clk);
        check(par_data == '0, "R8 word low in power-down", par_data, 0);
        check(!par_clk && !locked && !failsafe, "R8 flags low in power-down",
              {par_clk, locked, failsafe}, 0);
        run_frame(rnd_word(), 1'b0, lk);
        run_frame(rnd_word(), 1'b0, lk);
        check(par_data == '0 && !locked, "R8 frames ignored in power-down", {par_data, locked}, 0);
        @(negedge clk);
        pwr_n = 1; prev_ok = 0;
        wait_lock(f_det + LOCKF, "R8 settle before relock");
        for (int i = 0; i < 6; i++) run_frame(rnd_word(), 1'b0, lk);

        summary();
    end
endmodule